// File: doc/BRIEF.md
# Fractional-Step SCL Tick Generator

This block derives the serial clock timing of an I2C master from a much faster input clock. Every input clock cycle an accumulator gains a programmable step (the increment). Once the total reaches a programmable threshold (the decrement), the threshold is subtracted and a one-cycle tick is emitted. With an increment of one, the tick period is exactly the decrement in input cycles. With a larger increment, the average tick rate is increment/decrement of the input clock. The decrement is normally set to the input clock divided by twice the wanted bus rate, so that one tick marks each SCL half-period.

Two configuration words with the same layout exist: one for standard/fast operation and one for high-speed operation. A mode input chooses between them. The words and the mode are captured only while the run enable is low, so a running controller sees a frozen setting. Settings the accumulator cannot honour are flagged and produce no ticks. The block also drives an SCL level: it flips on every tick while a transfer is active and rests high otherwise.

Top module: `scl_tick_gen`

## Requirements
- R1: After reset, `tick` is 0 and `sclOut` is 1.
- R2: In each configuration word the increment occupies bits [26:16] and the decrement occupies bits [10:0]. All other bits have no effect on `tick` or `cfgInvalid`.
- R3: While running with a valid setting and increment 1, the first tick appears after the decrement-th rising edge with `runEn` high, and ticks then repeat every decrement cycles, one cycle wide. In general, each edge adds the increment to an accumulator that starts at 0; when the sum is at or above the decrement, the decrement is subtracted and `tick` is high for the following cycle.
- R4: With an increment above 1, ticks follow the same accumulate-and-subtract rule, giving increment ticks per decrement cycles on average.
- R5: `hsMode` = 1 selects `cfgHigh` and `hsMode` = 0 selects `cfgNormal`.
- R6: `cfgInvalid` is 1 when the selected decrement is 6 or less, or when the selected increment exceeds the decrement. In that state no tick is produced. A decrement of 7 with increment 1 is valid.
- R7: An increment of 0 with a valid decrement produces no ticks and does not raise `cfgInvalid`.
- R8: Changes to `cfgNormal`, `cfgHigh` or `hsMode` while `runEn` is high do not affect ticks. The captured setting is the one present at the last edge with `runEn` low.
- R9: While `xferActive` is 1, `sclOut` inverts on the clock edge after each tick cycle and otherwise holds. While `xferActive` is 0, `sclOut` is 1 from the next edge on.
- R10: While `runEn` is low no tick is produced, and each new run starts from an empty accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Controller running; freezes the configuration while high |
| hsMode | input | 1 | 1 selects the high-speed configuration word |
| cfgNormal | input | 32 | Standard/fast configuration word |
| cfgHigh | input | 32 | High-speed configuration word |
| xferActive | input | 1 | Transfer in progress; lets SCL toggle |
| tick | output | 1 | One-cycle SCL half-period tick |
| sclOut | output | 1 | Generated SCL level |
| cfgInvalid | output | 1 | Selected setting cannot be used |

## Verification
The assertions assume that the configuration is changed only through the capture path. So the decrement seen by the datapath is constant during a run, and the accumulator can be required to stay below it whenever a step is taken. They also assume `xferActive` is a plain level with no timing relation to `tick`. The stimulus changes every input just after a rising edge. It sets the words and the mode with `runEn` low and leaves two edges for capture before starting a run. Writes made during a run are deliberate, and they only touch the inputs that must be ignored.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  // strobes handed from the control side to the datapath
  typedef struct packed {
    logic accClear;   // empty the accumulator, no tick
    logic accStep;    // add the increment this cycle
  } sclkStrobe_t;
endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl #(
  parameter int CFG_W   = 32,
  parameter int FIELD_W = 11,
  parameter int INC_LSB = 16,
  parameter int DEC_LSB = 0,
  parameter int MIN_DEC = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    runEn,
  input  logic                    hsMode,
  input  logic [CFG_W-1:0]        cfgNormal,
  input  logic [CFG_W-1:0]        cfgHigh,
  output logic [FIELD_W-1:0]      incVal,
  output logic [FIELD_W-1:0]      decVal,
  output logic                    cfgInvalid,
  output sclk_pkg::sclkStrobe_t   strobes
);
  localparam logic [FIELD_W-1:0] DEC_FLOOR = FIELD_W'(MIN_DEC);

  logic [CFG_W-1:0] normQ, highQ;
  logic             hsQ;
  logic [CFG_W-1:0] selWord;

  // capture the setting only while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normQ <= '0;
      highQ <= '0;
      hsQ   <= 1'b0;
    end else if (!runEn) begin
      normQ <= cfgNormal;
      highQ <= cfgHigh;
      hsQ   <= hsMode;
    end
  end

  always_comb begin
    selWord    = hsQ ? highQ : normQ;
    incVal     = selWord[INC_LSB +: FIELD_W];
    decVal     = selWord[DEC_LSB +: FIELD_W];
    cfgInvalid = (decVal <= DEC_FLOOR) || (incVal > decVal);
    strobes.accClear = !runEn;
    strobes.accStep  = runEn && !cfgInvalid && (incVal != '0);
  end

  // R8: captured words stay put across consecutive running cycles
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && $past(runEn)) |-> ($stable(normQ) && $stable(highQ) && $stable(hsQ)));

endmodule

// File: rtl/sclk_datapath.sv
module sclk_datapath #(
  parameter int FIELD_W = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sclk_pkg::sclkStrobe_t   strobes,
  input  logic [FIELD_W-1:0]      incVal,
  input  logic [FIELD_W-1:0]      decVal,
  input  logic                    xferActive,
  output logic                    tick,
  output logic                    sclOut
);
  localparam int ACC_W = FIELD_W + 1;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] sum;
  logic             hit;

  always_comb begin
    sum = accQ + ACC_W'(incVal);
    hit = strobes.accStep && (sum >= ACC_W'(decVal));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      tick <= 1'b0;
    end else if (strobes.accClear) begin
      accQ <= '0;
      tick <= 1'b0;
    end else begin
      if (strobes.accStep) accQ <= hit ? (sum - ACC_W'(decVal)) : sum;
      tick <= hit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sclOut <= 1'b1;
    else if (!xferActive) sclOut <= 1'b1;
    else if (tick)        sclOut <= ~sclOut;
  end

  // R3: the remainder always stays below the threshold when a step is taken
  assert_acc_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accStep |-> (accQ < ACC_W'(decVal)));
  // R10: a stopped controller emits nothing
  assert_quiet_stopped_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accClear |=> !tick);
  // R9: idle SCL rests high
  assert_scl_idle_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |=> sclOut);
  // R9: no tick, no SCL movement during a transfer
  assert_scl_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && !tick) |=> $stable(sclOut));

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int CFG_W   = 32,
  parameter int FIELD_W = 11,
  parameter int INC_LSB = 16,
  parameter int DEC_LSB = 0,
  parameter int MIN_DEC = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             hsMode,
  input  logic [CFG_W-1:0] cfgNormal,
  input  logic [CFG_W-1:0] cfgHigh,
  input  logic             xferActive,
  output logic             tick,
  output logic             sclOut,
  output logic             cfgInvalid
);
  sclk_pkg::sclkStrobe_t strobes;
  logic [FIELD_W-1:0]    incVal;
  logic [FIELD_W-1:0]    decVal;

  sclk_ctrl #(
    .CFG_W(CFG_W), .FIELD_W(FIELD_W), .INC_LSB(INC_LSB),
    .DEC_LSB(DEC_LSB), .MIN_DEC(MIN_DEC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .hsMode(hsMode),
    .cfgNormal(cfgNormal), .cfgHigh(cfgHigh),
    .incVal(incVal), .decVal(decVal), .cfgInvalid(cfgInvalid),
    .strobes(strobes)
  );

  sclk_datapath #(.FIELD_W(FIELD_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .incVal(incVal), .decVal(decVal), .xferActive(xferActive),
    .tick(tick), .sclOut(sclOut)
  );

  // R6: an unusable setting never yields a tick
  assert_invalid_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgInvalid |=> !tick);

endmodule

// File: tb/sim_scl_tick_gen.sv
`timescale 1ns/1ps
module sim_scl_tick_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        hsMode = 1'b0;
  logic [31:0] cfgNormal = '0;
  logic [31:0] cfgHigh = '0;
  logic        xferActive = 1'b0;
  logic        tick, sclOut, cfgInvalid;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int expQ[$];
  string curTag = "R3";
  logic sclExp = 1'b1;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_tick_gen u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .hsMode(hsMode),
    .cfgNormal(cfgNormal), .cfgHigh(cfgHigh), .xferActive(xferActive),
    .tick(tick), .sclOut(sclOut), .cfgInvalid(cfgInvalid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mkWord(input int inc, input int dec);
    return (32'(inc) << 16) | 32'(dec);
  endfunction

  // monitor: pops expected tick cycles and tracks SCL level
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (expQ.size() > 0 && expQ[0] < cyc) begin
        check(0, {curTag, " missing tick"}, 0, expQ[0]);
        void'(expQ.pop_front());
      end
      if (tick) begin
        if (expQ.size() == 0) check(0, {curTag, " unexpected tick"}, cyc, -1);
        else check(expQ.pop_front() == cyc, curTag, cyc, cyc);
      end
      check(sclOut == sclExp, "R9 scl level", sclOut, sclExp);
      sclExp = xferActive ? (tick ? ~sclExp : sclExp) : 1'b1;
    end
  end

  // driver: configure while stopped, then run and push expected ticks
  task automatic runPhase(input string tag, input logic [31:0] wn, input logic [31:0] wh,
                          input bit hs, input bit xfer, input int nCyc,
                          input int expInvalid, input bit disturb);
    int inc, dec, acc, s, startCyc;
    bit valid;
    logic [31:0] w;
    @(posedge clk); #1;
    runEn = 1'b0; cfgNormal = wn; cfgHigh = wh; hsMode = hs; xferActive = xfer;
    curTag = tag;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check(cfgInvalid == expInvalid[0], {tag, " cfgInvalid"}, cfgInvalid, expInvalid);
    w = hs ? wh : wn;
    inc = int'(w[26:16]); dec = int'(w[10:0]);
    valid = (dec > 6) && (inc <= dec);
    @(posedge clk); #1;
    runEn = 1'b1;
    startCyc = cyc + 1;
    acc = 0;
    for (int n = 1; n <= nCyc; n++) begin
      if (valid && inc != 0) begin
        s = acc + inc;
        if (s >= dec) begin acc = s - dec; expQ.push_back(startCyc + n - 1); end
        else acc = s;
      end
    end
    for (int k = 0; k < nCyc; k++) begin
      @(posedge clk);
      if (disturb && k == 4) begin
        #1; cfgNormal = mkWord(1, 7); cfgHigh = mkWord(1, 3); hsMode = ~hs;
      end
    end
    #1; runEn = 1'b0;
    for (int k = 0; k < 5; k++) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, {tag, " all ticks seen"}, expQ.size(), 0);
    check(tick == 1'b0, "R10 stopped no tick", tick, 0);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      check(0, "watchdog", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tick == 1'b0, "R1 reset tick", tick, 0);
    check(sclOut == 1'b1, "R1 reset scl", sclOut, 1);
    #1; rstN = 1'b1;
    runPhase("R3", mkWord(1, 8), '0, 0, 1, 60, 0, 0);
    runPhase("R4", mkWord(3, 10), '0, 0, 1, 70, 0, 0);
    runPhase("R5", mkWord(0, 3), mkWord(1, 7), 1, 1, 50, 0, 0);
    runPhase("R5", mkWord(1, 9), mkWord(0, 2), 0, 1, 40, 0, 0);
    runPhase("R6", mkWord(1, 6), '0, 0, 1, 30, 1, 0);
    runPhase("R6", mkWord(12, 10), '0, 0, 1, 30, 1, 0);
    runPhase("R6", mkWord(1, 7), '0, 0, 1, 30, 0, 0);
    runPhase("R7", mkWord(0, 20), '0, 0, 1, 40, 0, 0);
    runPhase("R2", 32'hF800_F800 | mkWord(1, 9), '0, 0, 1, 45, 0, 0);
    runPhase("R8", mkWord(2, 11), mkWord(1, 13), 0, 1, 60, 0, 1);
    runPhase("R9", mkWord(1, 7), '0, 0, 0, 40, 0, 0);
    runPhase("R10", mkWord(2, 9), '0, 0, 1, 13, 0, 0);
    runPhase("R10", mkWord(2, 9), '0, 0, 1, 20, 0, 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule